// File: doc/BRIEF.md
# Register-memory single-bit logic unit

This block combines one bit of an 8-bit register with one bit of a byte in memory. The register may be accumulator A, accumulator B or the condition-code register. A command carries a three-bit operation code, a one-byte post-byte and an 8-bit direct offset. The post-byte names the register and the two bit positions. Any register bit may be paired with any memory bit.

The block forms the memory address by placing the direct-page value above the offset. It fetches that byte over a request/valid handshake and computes the new bit. It then writes back one of two things: the whole register with one bit changed, or, for a bit store, the memory byte with one bit changed. The surrounding core supplies the register values and the direct page at the start of a command. The core applies the register write-back port, and the memory system accepts the single write strobe.

Top module: `bit_xfer_unit`

## Requirements
- R1: While reset is held and after it is released, `busy`, `done`, `illegal`, `mem_rd_req`, `mem_wr_en` and `reg_wr_en` are all low until a command is started.
- R2: From the cycle after an accepted legal `start`, `mem_rd_req` stays high with `mem_addr` = {`dp`, `dir_off`} as captured at start. It stays high and unchanged until the cycle in which `mem_rd_valid` is sampled high.
- R3: The post-byte is decoded as follows. Bits 7:6 select the register (00 = CC, 01 = A, 10 = B). Bits 5:3 give the memory bit index and bits 2:0 give the register bit index. The 2-bit register code is presented on `reg_wr_sel` during a register write.
- R4: Operation codes 0 to 5 are AND, AND-with-complement, OR, OR-with-complement, XOR and XOR-with-complement. The new register bit is reg_bit OP (mem_bit XOR op[0]).
- R5: Operation code 6 (bit load) sets the selected register bit to the selected memory bit.
- R6: For codes 0 to 6, every register bit other than the selected one is returned unchanged, and `mem_wr_en` stays low.
- R7: Operation code 7 (bit store) writes the fetched byte back with only the selected memory bit replaced by the selected register bit. It raises no register write.
- R8: The single write (`reg_wr_en` or `mem_wr_en`) is high for exactly the one cycle after the cycle in which `mem_rd_valid` is sampled. `done` is high for exactly the cycle after that write.
- R9: A register code of 11 gives `done` and `illegal` together in the cycle after `start`. It raises no read and no write.
- R10: `start` is ignored while `busy` is high.
- R11: The selected register value, the direct page and the offset are sampled in the `start` cycle, and later changes on those inputs do not affect the command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a command (accepted when not busy) |
| op | input | 3 | Operation code 0..7 |
| post_byte | input | 8 | Register select and bit indices |
| dir_off | input | 8 | Direct-page offset |
| dp | input | 8 | Direct-page register value |
| acc_a | input | 8 | Accumulator A value |
| acc_b | input | 8 | Accumulator B value |
| cc | input | 8 | Condition-code register value |
| mem_addr | output | 16 | Memory byte address |
| mem_rd_req | output | 1 | Read request, held until valid |
| mem_rd_valid | input | 1 | Read data valid |
| mem_rd_data | input | 8 | Read data |
| mem_wr_en | output | 1 | One-cycle memory write strobe |
| mem_wdata | output | 8 | Memory write data |
| reg_wr_en | output | 1 | One-cycle register write strobe |
| reg_wr_sel | output | 2 | Register code to write |
| reg_wr_data | output | 8 | New register value |
| done | output | 1 | Command complete pulse |
| illegal | output | 1 | Illegal register code, with done |
| busy | output | 1 | Command in progress |

## Verification
The assertions assume the memory side behaves in a fixed way. It raises `mem_rd_valid` only while a read is requested, and for a single cycle per request. The bench's memory model answers each request once, after a random wait of zero to three cycles, and drops valid at the next falling edge. The assertions also assume that `start` may arrive at any time. The stimulus therefore deliberately pulses `start` with an illegal post-byte while a read is pending, and changes the register, page and offset inputs right after acceptance.

// File: rtl/bxu_pkg.sv
package bxu_pkg;

  typedef enum logic [2:0] {
    OP_AND   = 3'd0,
    OP_ANDN  = 3'd1,
    OP_OR    = 3'd2,
    OP_ORN   = 3'd3,
    OP_XOR   = 3'd4,
    OP_XORN  = 3'd5,
    OP_LOAD  = 3'd6,
    OP_STORE = 3'd7
  } bxu_op_e;

  typedef enum logic [1:0] {
    SEL_CC  = 2'b00,
    SEL_A   = 2'b01,
    SEL_B   = 2'b10,
    SEL_BAD = 2'b11
  } bxu_sel_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2,
    ST_FIN   = 2'd3
  } bxu_state_e;

endpackage

// File: rtl/bxu_rst_sync.sv
module bxu_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_n_sync = chain_q[STAGES-1];

endmodule

// File: rtl/bxu_decode.sv
module bxu_decode
  import bxu_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  localparam int unsigned IDX_W = $clog2(DATA_W),
  localparam int unsigned PB_W  = 2 + 2 * IDX_W
) (
  input  logic [PB_W-1:0]   post_byte,
  input  logic [DATA_W-1:0] acc_a,
  input  logic [DATA_W-1:0] acc_b,
  input  logic [DATA_W-1:0] cc,
  output bxu_sel_e          sel,
  output logic [IDX_W-1:0]  mem_idx,
  output logic [IDX_W-1:0]  reg_idx,
  output logic              bad_sel,
  output logic [DATA_W-1:0] reg_val
);

  always_comb begin
    sel     = bxu_sel_e'(post_byte[PB_W-1 -: 2]);
    mem_idx = post_byte[2*IDX_W-1 -: IDX_W];
    reg_idx = post_byte[IDX_W-1:0];
    bad_sel = (sel == SEL_BAD);
  end

  always_comb begin
    unique case (sel)
      SEL_CC:  reg_val = cc;
      SEL_A:   reg_val = acc_a;
      SEL_B:   reg_val = acc_b;
      default: reg_val = '0;
    endcase
  end

endmodule

// File: rtl/bxu_alu.sv
module bxu_alu
  import bxu_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  localparam int unsigned IDX_W = $clog2(DATA_W)
) (
  input  bxu_op_e           op,
  input  logic [DATA_W-1:0] reg_val,
  input  logic [DATA_W-1:0] mem_val,
  input  logic [IDX_W-1:0]  reg_idx,
  input  logic [IDX_W-1:0]  mem_idx,
  output logic [DATA_W-1:0] reg_new,
  output logic [DATA_W-1:0] mem_new
);

  logic r_bit;
  logic m_bit;
  logic m_eff;
  logic res_bit;

  always_comb begin
    r_bit = reg_val[reg_idx];
    m_bit = mem_val[mem_idx];
    m_eff = m_bit ^ op[0];
    unique case (op)
      OP_AND, OP_ANDN: res_bit = r_bit & m_eff;
      OP_OR,  OP_ORN:  res_bit = r_bit | m_eff;
      OP_XOR, OP_XORN: res_bit = r_bit ^ m_eff;
      OP_LOAD:         res_bit = m_bit;
      default:         res_bit = r_bit;
    endcase
  end

  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    assign reg_new[i] = (reg_idx == IDX_W'(i)) ? res_bit : reg_val[i];
    assign mem_new[i] = (mem_idx == IDX_W'(i)) ? r_bit   : mem_val[i];
  end

endmodule

// File: rtl/bxu_ctrl.sv
module bxu_ctrl
  import bxu_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  localparam int unsigned IDX_W  = $clog2(DATA_W),
  localparam int unsigned ADDR_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  bxu_op_e           op_in,
  input  bxu_sel_e          sel_in,
  input  logic [IDX_W-1:0]  midx_in,
  input  logic [IDX_W-1:0]  ridx_in,
  input  logic              bad_in,
  input  logic [DATA_W-1:0] regv_in,
  input  logic [DATA_W-1:0] dp_in,
  input  logic [DATA_W-1:0] off_in,
  input  logic              mem_rd_valid,
  input  logic [DATA_W-1:0] mem_rd_data,
  output bxu_op_e           op_q,
  output bxu_sel_e          sel_q,
  output logic [IDX_W-1:0]  midx_q,
  output logic [IDX_W-1:0]  ridx_q,
  output logic [DATA_W-1:0] regv_q,
  output logic [DATA_W-1:0] rdata_q,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd_req,
  output logic              mem_wr_en,
  output logic              reg_wr_en,
  output logic              done,
  output logic              illegal,
  output logic              busy
);

  bxu_state_e        state_q, state_d;
  logic              cmd_en;
  logic              data_en;
  logic              bad_q;
  logic [DATA_W-1:0] dp_q;
  logic [DATA_W-1:0] off_q;

  // next-state logic
  always_comb begin
    state_d = state_q;
    cmd_en  = 1'b0;
    data_en = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          cmd_en  = 1'b1;
          state_d = bad_in ? ST_FIN : ST_READ;
        end
      end
      ST_READ: begin
        if (mem_rd_valid) begin
          data_en = 1'b1;
          state_d = ST_WRITE;
        end
      end
      ST_WRITE: state_d = ST_FIN;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  // command capture, enabled on acceptance
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q   <= OP_AND;
      sel_q  <= SEL_CC;
      midx_q <= '0;
      ridx_q <= '0;
      regv_q <= '0;
      dp_q   <= '0;
      off_q  <= '0;
      bad_q  <= 1'b0;
    end else if (cmd_en) begin
      op_q   <= op_in;
      sel_q  <= sel_in;
      midx_q <= midx_in;
      ridx_q <= ridx_in;
      regv_q <= regv_in;
      dp_q   <= dp_in;
      off_q  <= off_in;
      bad_q  <= bad_in;
    end
  end

  // fetched byte capture
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (data_en) begin
      rdata_q <= mem_rd_data;
    end
  end

  always_comb begin
    mem_addr   = {dp_q, off_q};
    busy       = (state_q != ST_IDLE);
    mem_rd_req = (state_q == ST_READ);
    mem_wr_en  = (state_q == ST_WRITE) && (op_q == OP_STORE);
    reg_wr_en  = (state_q == ST_WRITE) && (op_q != OP_STORE);
    done       = (state_q == ST_FIN);
    illegal    = (state_q == ST_FIN) && bad_q;
  end

  // R2
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_req && !mem_rd_valid) |=> (mem_rd_req && $stable(mem_addr)));

  // R8
  wr_then_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_en || mem_wr_en) |=> done);

  // R8
  valid_then_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_req && mem_rd_valid) |=> (reg_wr_en || mem_wr_en));

  // R9
  illegal_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> (done && !$past(mem_rd_req) && !$past(reg_wr_en) && !$past(mem_wr_en)));

  // R7
  one_action_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({reg_wr_en, mem_wr_en, mem_rd_req, done}));

  // R10
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> ($stable(sel_q) && $stable(mem_addr) && $stable(regv_q)));

endmodule

// File: rtl/bit_xfer_unit.sv
module bit_xfer_unit
  import bxu_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  localparam int unsigned IDX_W  = $clog2(DATA_W),
  localparam int unsigned PB_W   = 2 + 2 * IDX_W,
  localparam int unsigned ADDR_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [2:0]        op,
  input  logic [PB_W-1:0]   post_byte,
  input  logic [DATA_W-1:0] dir_off,
  input  logic [DATA_W-1:0] dp,
  input  logic [DATA_W-1:0] acc_a,
  input  logic [DATA_W-1:0] acc_b,
  input  logic [DATA_W-1:0] cc,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd_req,
  input  logic              mem_rd_valid,
  input  logic [DATA_W-1:0] mem_rd_data,
  output logic              mem_wr_en,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              reg_wr_en,
  output logic [1:0]        reg_wr_sel,
  output logic [DATA_W-1:0] reg_wr_data,
  output logic              done,
  output logic              illegal,
  output logic              busy
);

  logic              rst_n_s;
  bxu_sel_e          dec_sel;
  logic [IDX_W-1:0]  dec_midx;
  logic [IDX_W-1:0]  dec_ridx;
  logic              dec_bad;
  logic [DATA_W-1:0] dec_regv;
  bxu_op_e           op_q;
  bxu_sel_e          sel_q;
  logic [IDX_W-1:0]  midx_q;
  logic [IDX_W-1:0]  ridx_q;
  logic [DATA_W-1:0] regv_q;
  logic [DATA_W-1:0] rdata_q;

  bxu_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  bxu_decode #(.DATA_W(DATA_W)) u_dec (
    .post_byte (post_byte),
    .acc_a     (acc_a),
    .acc_b     (acc_b),
    .cc        (cc),
    .sel       (dec_sel),
    .mem_idx   (dec_midx),
    .reg_idx   (dec_ridx),
    .bad_sel   (dec_bad),
    .reg_val   (dec_regv)
  );

  bxu_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n_s),
    .start        (start),
    .op_in        (bxu_op_e'(op)),
    .sel_in       (dec_sel),
    .midx_in      (dec_midx),
    .ridx_in      (dec_ridx),
    .bad_in       (dec_bad),
    .regv_in      (dec_regv),
    .dp_in        (dp),
    .off_in       (dir_off),
    .mem_rd_valid (mem_rd_valid),
    .mem_rd_data  (mem_rd_data),
    .op_q         (op_q),
    .sel_q        (sel_q),
    .midx_q       (midx_q),
    .ridx_q       (ridx_q),
    .regv_q       (regv_q),
    .rdata_q      (rdata_q),
    .mem_addr     (mem_addr),
    .mem_rd_req   (mem_rd_req),
    .mem_wr_en    (mem_wr_en),
    .reg_wr_en    (reg_wr_en),
    .done         (done),
    .illegal      (illegal),
    .busy         (busy)
  );

  bxu_alu #(.DATA_W(DATA_W)) u_alu (
    .op      (op_q),
    .reg_val (regv_q),
    .mem_val (rdata_q),
    .reg_idx (ridx_q),
    .mem_idx (midx_q),
    .reg_new (reg_wr_data),
    .mem_new (mem_wdata)
  );

  assign reg_wr_sel = sel_q;

  // R6
  reg_one_bit_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    reg_wr_en |-> ($countones(reg_wr_data ^ regv_q) <= 1));

  // R7
  mem_one_bit_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    mem_wr_en |-> ($countones(mem_wdata ^ rdata_q) <= 1));

endmodule

// File: tb/bit_xfer_unit_tb.sv
module bit_xfer_unit_tb;

  logic        clk;
  logic        rst_n;
  logic        start;
  logic [2:0]  op;
  logic [7:0]  post_byte;
  logic [7:0]  dir_off;
  logic [7:0]  dp;
  logic [7:0]  acc_a;
  logic [7:0]  acc_b;
  logic [7:0]  cc;
  logic [15:0] mem_addr;
  logic        mem_rd_req;
  logic        mem_rd_valid;
  logic [7:0]  mem_rd_data;
  logic        mem_wr_en;
  logic [7:0]  mem_wdata;
  logic        reg_wr_en;
  logic [1:0]  reg_wr_sel;
  logic [7:0]  reg_wr_data;
  logic        done;
  logic        illegal;
  logic        busy;

  int checks;
  int errors;
  int cycles;
  bit finished;

  bit_xfer_unit u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .op           (op),
    .post_byte    (post_byte),
    .dir_off      (dir_off),
    .dp           (dp),
    .acc_a        (acc_a),
    .acc_b        (acc_b),
    .cc           (cc),
    .mem_addr     (mem_addr),
    .mem_rd_req   (mem_rd_req),
    .mem_rd_valid (mem_rd_valid),
    .mem_rd_data  (mem_rd_data),
    .mem_wr_en    (mem_wr_en),
    .mem_wdata    (mem_wdata),
    .reg_wr_en    (reg_wr_en),
    .reg_wr_sel   (reg_wr_sel),
    .reg_wr_data  (reg_wr_data),
    .done         (done),
    .illegal      (illegal),
    .busy         (busy)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(string req, string what, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_reg(logic [2:0] o, logic [7:0] rv, logic [7:0] mv,
                                         logic [2:0] mi, logic [2:0] ri);
    logic r, m, me, res;
    logic [7:0] out;
    r  = rv[ri];
    m  = mv[mi];
    me = m ^ o[0];
    case (o)
      3'd0, 3'd1: res = r & me;
      3'd2, 3'd3: res = r | me;
      3'd4, 3'd5: res = r ^ me;
      3'd6:       res = m;
      default:    res = r;
    endcase
    out = rv;
    out[ri] = res;
    return out;
  endfunction

  function automatic logic [7:0] exp_mem(logic [7:0] rv, logic [7:0] mv,
                                         logic [2:0] mi, logic [2:0] ri);
    logic [7:0] out;
    out = mv;
    out[mi] = rv[ri];
    return out;
  endfunction

  task automatic run_op(logic [2:0] o, logic [1:0] sel, logic [2:0] mi, logic [2:0] ri,
                        logic [7:0] pg, logic [7:0] off, logic [7:0] a, logic [7:0] b,
                        logic [7:0] c, logic [7:0] mbyte, int lat, bit poke);
    logic [7:0] rv;
    string dreq;
    rv = (sel == 2'b00) ? c : (sel == 2'b01) ? a : b;
    @(negedge clk);
    op = o; post_byte = {sel, mi, ri}; dp = pg; dir_off = off;
    acc_a = a; acc_b = b; cc = c; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    // R11: disturb captured inputs
    acc_a = ~a; acc_b = ~b; cc = ~c; dp = ~pg; dir_off = ~off; post_byte = ~post_byte; op = ~o;
    if (sel == 2'b11) begin
      check("R9", "done", {15'd0, done}, 16'd1);
      check("R9", "illegal", {15'd0, illegal}, 16'd1);
      check("R9", "no read", {15'd0, mem_rd_req}, 16'd0);
      check("R9", "no write", {14'd0, reg_wr_en, mem_wr_en}, 16'd0);
      @(posedge clk);
      @(negedge clk);
      check("R9", "idle after", {15'd0, busy}, 16'd0);
      return;
    end
    check("R2", "read req", {15'd0, mem_rd_req}, 16'd1);
    check("R2", "addr", mem_addr, {pg, off});
    for (int k = 0; k < lat; k++) begin
      if (poke) begin
        start = 1'b1; post_byte = 8'hFF;
      end
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
      check("R2", "req held", {15'd0, mem_rd_req}, 16'd1);
      check("R11", "addr held", mem_addr, {pg, off});
      if (poke) check("R10", "no illegal while busy", {15'd0, illegal}, 16'd0);
    end
    mem_rd_valid = 1'b1;
    mem_rd_data  = mbyte;
    @(posedge clk);
    @(negedge clk);
    mem_rd_valid = 1'b0;
    mem_rd_data  = ~mbyte;
    if (o == 3'd7) begin
      check("R7", "mem write", {15'd0, mem_wr_en}, 16'd1);
      check("R7", "no reg write", {15'd0, reg_wr_en}, 16'd0);
      check("R7", "wdata", {8'd0, mem_wdata}, {8'd0, exp_mem(rv, mbyte, mi, ri)});
      check("R2", "addr at write", mem_addr, {pg, off});
    end else begin
      dreq = (o == 3'd6) ? "R5" : "R4";
      check("R8", "reg write", {15'd0, reg_wr_en}, 16'd1);
      check("R6", "no mem write", {15'd0, mem_wr_en}, 16'd0);
      check("R3", "reg sel", {14'd0, reg_wr_sel}, {14'd0, sel});
      check(dreq, "reg data", {8'd0, reg_wr_data}, {8'd0, exp_reg(o, rv, mbyte, mi, ri)});
      check("R6", "other bits", {8'd0, reg_wr_data & ~(8'd1 << ri)},
            {8'd0, rv & ~(8'd1 << ri)});
    end
    check("R8", "no done yet", {15'd0, done}, 16'd0);
    @(posedge clk);
    @(negedge clk);
    check("R8", "done", {15'd0, done}, 16'd1);
    check("R8", "write over", {14'd0, reg_wr_en, mem_wr_en}, 16'd0);
    check("R9", "no illegal", {15'd0, illegal}, 16'd0);
    @(posedge clk);
    @(negedge clk);
    check("R8", "done one cycle", {15'd0, done}, 16'd0);
    check("R10", "idle", {15'd0, busy}, 16'd0);
  endtask

  task automatic finish_up();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    cycles = 0;
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        errors++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
        finish_up();
      end
    end
  end

  initial begin
    logic [7:0] r1, r2, r3, r4, r5, r6;
    checks = 0; errors = 0; finished = 1'b0;
    void'($urandom(32'h5EED_0042));
    rst_n = 1'b0; start = 1'b0; op = 3'd0; post_byte = 8'd0; dir_off = 8'd0; dp = 8'd0;
    acc_a = 8'd0; acc_b = 8'd0; cc = 8'd0; mem_rd_valid = 1'b0; mem_rd_data = 8'd0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1
    check("R1", "outputs in reset",
          {10'd0, busy, done, illegal, mem_rd_req, mem_wr_en, reg_wr_en}, 16'd0);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check("R1", "outputs after reset",
          {10'd0, busy, done, illegal, mem_rd_req, mem_wr_en, reg_wr_en}, 16'd0);

    // directed: every op on every legal register, bit 7 <-> bit 0
    for (int o = 0; o < 8; o++) begin
      for (int s = 0; s < 3; s++) begin
        run_op(3'(o), 2'(s), 3'd7, 3'd0, 8'h12, 8'h34, 8'hA5, 8'h3C, 8'h0F, 8'h80, 0, 1'b0);
        run_op(3'(o), 2'(s), 3'd0, 3'd7, 8'hFF, 8'h00, 8'h7E, 8'h81, 8'hF0, 8'hFE, 3, 1'b1);
      end
    end
    // illegal code
    run_op(3'd0, 2'b11, 3'd2, 3'd5, 8'h00, 8'h10, 8'h01, 8'h02, 8'h03, 8'hAA, 0, 1'b0);
    run_op(3'd7, 2'b11, 3'd7, 3'd7, 8'hE0, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'h00, 0, 1'b0);
    // random mix
    for (int n = 0; n < 400; n++) begin
      r1 = 8'($urandom); r2 = 8'($urandom); r3 = 8'($urandom);
      r4 = 8'($urandom); r5 = 8'($urandom); r6 = 8'($urandom);
      run_op(3'($urandom_range(0, 7)), 2'($urandom_range(0, 3)), 3'($urandom),
             3'($urandom), r1, r2, r3, r4, r5, r6, int'($urandom_range(0, 3)),
             1'($urandom));
    end
    finish_up();
  end

endmodule